// File: doc/BRIEF.md
# Extraction Word Stream Decoder

This block turns the 32-bit word stream read from a CPU extraction queue back into Ethernet frames. Each frame in the stream opens with a fixed-length internal frame header. The block parses the ingress port number out of that header and then reads the frame body. Reserved words in the range 0x80000000 to 0x80000007 act as in-band controls: they end a frame, give the valid byte count of its last word, escape a literal word, abort or prune the frame, or simply fill a gap when the queue has nothing ready.

The output carries one byte per beat, most significant byte of each word first. The trailing 4-byte frame check sequence is held back and never sent. The final beat is marked with a last flag, and on that beat a drop flag states whether the receiver must discard the frame. A frame is dropped when it was aborted, when it was pruned, or when it ran past a configured byte limit. Frames from a port that is out of range or not enabled are read through to their terminator and produce no output. One configuration bit byte-reverses every input word before it is compared and unpacked.

Top module: `xtr_stream_decoder`

## Requirements
- R1: The first HDR_WORDS (default 9) accepted words of every frame are header words and produce no output beat.
- R2: The ingress port is bits 20:14 of header word 7. This equals header bytes 27..30 joined big-endian, shifted right by 5, bits 7:1. `out_port` carries it on every beat of the frame.
- R3: A word 0x80000000..0x80000003 ends the frame. The data word just before it contributes 4 minus the code's low two bits bytes. Every earlier data word contributes 4 bytes.
- R4: Bytes of a data word leave most significant first. The last 4 bytes of the frame are not delivered, and `out_last` marks the final delivered byte. A frame of 4 bytes or fewer produces no beat.
- R5: After 0x80000006 the next word is taken as data even when it equals a control code.
- R6: 0x80000007 is skipped. It adds no bytes and does not end the frame.
- R7: 0x80000005 ends the frame, and the data word just before it is not delivered. The final beat has `out_drop`=1.
- R8: After 0x80000004 one more word is consumed and discarded, and the frame ends. All earlier data words count. The final beat has `out_drop`=1.
- R9: With `cfg_swap`=1 each input word is byte-reversed before it is classified and unpacked.
- R10: When the port is not below NUM_PORTS, or its `cfg_port_en` bit is 0, the frame is parsed to its terminator and no beat is produced.
- R11: At most `cfg_max_len` bytes, FCS included, are counted per frame. When a frame has more, the extra bytes are discarded and the final beat has `out_drop`=1.
- R12: `out_drop` is 1 only on a final beat. A frame that ends normally within the limit has `out_drop`=0.
- R13: After reset `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_swap | input | 1 | Byte-reverse each input word |
| cfg_port_en | input | NUM_PORTS | Enable bit per ingress port |
| cfg_max_len | input | LEN_W | Byte limit per frame, FCS included |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_drop | output | 1 | Discard the frame (final beat only) |
| out_port | output | PORT_W | Ingress port of the frame |

## Verification
A header counter that drifts by one word moves the port field, or lets a header word leak into the body. That shows up on the first beat of the next frame as a wrong `out_port` or wrong data. A lost escape or prune flag turns a literal word into a terminator, or the reverse. The beat count and the final beat's last and drop flags then differ from the expected ones at the end of that same frame. Errors in the FCS hold-back or the valid-byte count change the number of beats, so the first frame that uses a given end code reveals them.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

    typedef enum logic [2:0] {
        W_DATA,
        W_EOF,
        W_PRUNE,
        W_ABORT,
        W_ESC,
        W_NOTRDY
    } wkind_e;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_BODY,
        ST_UNPACK,
        ST_END
    } st_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
        logic       drop;
    } beat_t;

    localparam logic [28:0] CTRL_PREFIX = 29'h1000_0000;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic wkind_e classify(input logic [31:0] w);
        wkind_e k;
        k = W_DATA;
        if (w[31:3] == CTRL_PREFIX) begin
            unique case (w[2:0])
                3'd4:    k = W_PRUNE;
                3'd5:    k = W_ABORT;
                3'd6:    k = W_ESC;
                3'd7:    k = W_NOTRDY;
                default: k = W_EOF;
            endcase
        end
        return k;
    endfunction

    function automatic logic [2:0] eof_bytes(input logic [1:0] lo);
        return 3'd4 - {1'b0, lo};
    endfunction

endpackage

// File: rtl/xtr_hdr_capture.sv
module xtr_hdr_capture #(
    parameter int HDR_WORDS = 9,
    parameter int PORT_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [31:0]       word,
    output logic              done,
    output logic [PORT_W-1:0] port_now
);
    localparam int IDX_W   = $clog2(HDR_WORDS + 1);
    localparam int HI_BYTE = 27;
    localparam int HI_WORD = HI_BYTE / 4;
    localparam int LO_WORD = (HI_BYTE + 1) / 4;
    localparam int SHIFT   = 5;

    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        hi_byte_q;
    logic [PORT_W-1:0] port_q;
    logic [31:0]       joined;
    logic [PORT_W-1:0] port_calc;

    always_comb begin
        joined    = {hi_byte_q, word[31:8]};
        port_calc = joined[SHIFT+PORT_W:SHIFT+1];
        done      = take && (idx_q == IDX_W'(HDR_WORDS - 1));
        port_now  = (take && idx_q == IDX_W'(LO_WORD)) ? port_calc : port_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            hi_byte_q <= '0;
            port_q    <= '0;
        end else if (take) begin
            idx_q <= done ? '0 : idx_q + 1'b1;
            if (idx_q == IDX_W'(HI_WORD)) hi_byte_q <= word[7:0];
            if (idx_q == IDX_W'(LO_WORD)) port_q    <= port_calc;
        end
    end

    assert_hdr_idx_R1: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(HDR_WORDS));

endmodule

// File: rtl/xtr_fcs_holdback.sv
module xtr_fcs_holdback
    import xtr_pkg::*;
#(
    parameter int FCS_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       finish,
    input  logic       drop_in,
    output beat_t      beat
);
    localparam int DEPTH = FCS_BYTES + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [7:0]       sr [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full = (cnt_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            beat  <= '0;
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
            beat.valid <= 1'b0;
            beat.last  <= 1'b0;
            beat.drop  <= 1'b0;
            if (push) begin
                if (full) begin
                    beat.valid <= 1'b1;
                    beat.data  <= sr[0];
                    for (int i = 0; i < DEPTH - 1; i++) sr[i] <= sr[i+1];
                    sr[DEPTH-1] <= push_byte;
                end else begin
                    for (int i = 0; i < DEPTH; i++)
                        if (CNT_W'(i) == cnt_q) sr[i] <= push_byte;
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (finish) begin
                if (full) begin
                    beat.valid <= 1'b1;
                    beat.data  <= sr[0];
                    beat.last  <= 1'b1;
                    beat.drop  <= drop_in;
                end
                cnt_q <= '0;
            end
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    assert_drop_on_last_R12: assert property (@(posedge clk) disable iff (rst)
        beat.drop |-> (beat.last && beat.valid));

    assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        beat.last |=> !beat.valid);

endmodule

// File: rtl/xtr_stream_decoder.sv
module xtr_stream_decoder
    import xtr_pkg::*;
#(
    parameter int HDR_WORDS = 9,
    parameter int PORT_W    = 7,
    parameter int NUM_PORTS = 65,
    parameter int LEN_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_swap,
    input  logic [NUM_PORTS-1:0] cfg_port_en,
    input  logic [LEN_W-1:0]     cfg_max_len,
    input  logic                 in_valid,
    input  logic [31:0]          in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_last,
    output logic                 out_drop,
    output logic [PORT_W-1:0]    out_port
);
    localparam int EN_W = 1 << PORT_W;

    st_e               st_q;
    logic [31:0]       held_q, ux_q;
    logic              held_v_q, esc_q, prune_q, drop_q, long_q, discard_q, uend_q;
    logic [2:0]        ucnt_q;
    logic [LEN_W-1:0]  byte_cnt_q;
    logic [PORT_W-1:0] port_q;

    logic [31:0]       w_cmp;
    wkind_e            kind;
    logic              acc, hdr_take, hdr_done, port_ok, lit, push, finish;
    logic [PORT_W-1:0] port_now;
    logic [EN_W-1:0]   en_pad;
    beat_t             beat;

    always_comb begin
        w_cmp    = cfg_swap ? bswap32(in_data) : in_data;
        kind     = classify(w_cmp);
        in_ready = (st_q == ST_HDR) || (st_q == ST_BODY);
        acc      = in_valid && in_ready;
        hdr_take = acc && (st_q == ST_HDR);
        en_pad   = EN_W'(cfg_port_en);
        port_ok  = (int'(port_now) < NUM_PORTS) && en_pad[port_now];
        lit      = esc_q ? !prune_q : (kind == W_DATA);
        push     = (st_q == ST_UNPACK) && !discard_q && (byte_cnt_q < cfg_max_len);
        finish   = (st_q == ST_END);
    end

    xtr_hdr_capture #(.HDR_WORDS(HDR_WORDS), .PORT_W(PORT_W)) u_hdr (
        .clk(clk), .rst(rst), .take(hdr_take), .word(w_cmp),
        .done(hdr_done), .port_now(port_now)
    );

    xtr_fcs_holdback #(.FCS_BYTES(4)) u_hold (
        .clk(clk), .rst(rst), .push(push), .push_byte(ux_q[31:24]),
        .finish(finish), .drop_in(drop_q || long_q), .beat(beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HDR;
            held_q     <= '0;
            held_v_q   <= 1'b0;
            esc_q      <= 1'b0;
            prune_q    <= 1'b0;
            drop_q     <= 1'b0;
            long_q     <= 1'b0;
            discard_q  <= 1'b0;
            ux_q       <= '0;
            ucnt_q     <= '0;
            uend_q     <= 1'b0;
            byte_cnt_q <= '0;
            port_q     <= '0;
        end else begin
            unique case (st_q)
                ST_HDR: begin
                    if (hdr_done) begin
                        port_q    <= port_now;
                        discard_q <= !port_ok;
                        st_q      <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (acc) begin
                        if (esc_q && prune_q) begin
                            esc_q   <= 1'b0;
                            prune_q <= 1'b0;
                            drop_q  <= 1'b1;
                            if (held_v_q) begin
                                ux_q     <= held_q;
                                ucnt_q   <= 3'd4;
                                uend_q   <= 1'b1;
                                held_v_q <= 1'b0;
                                st_q     <= ST_UNPACK;
                            end else begin
                                st_q <= ST_END;
                            end
                        end else if (lit) begin
                            esc_q    <= 1'b0;
                            held_q   <= w_cmp;
                            held_v_q <= 1'b1;
                            if (held_v_q) begin
                                ux_q   <= held_q;
                                ucnt_q <= 3'd4;
                                uend_q <= 1'b0;
                                st_q   <= ST_UNPACK;
                            end
                        end else begin
                            unique case (kind)
                                W_ESC:   esc_q <= 1'b1;
                                W_PRUNE: begin
                                    esc_q   <= 1'b1;
                                    prune_q <= 1'b1;
                                end
                                W_ABORT: begin
                                    drop_q <= 1'b1;
                                    st_q   <= ST_END;
                                end
                                W_EOF: begin
                                    if (held_v_q) begin
                                        ux_q     <= held_q;
                                        ucnt_q   <= eof_bytes(w_cmp[1:0]);
                                        uend_q   <= 1'b1;
                                        held_v_q <= 1'b0;
                                        st_q     <= ST_UNPACK;
                                    end else begin
                                        st_q <= ST_END;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_UNPACK: begin
                    ux_q   <= {ux_q[23:0], 8'h00};
                    ucnt_q <= ucnt_q - 1'b1;
                    if (!discard_q && byte_cnt_q >= cfg_max_len) long_q <= 1'b1;
                    if (push) byte_cnt_q <= byte_cnt_q + 1'b1;
                    if (ucnt_q == 3'd1) st_q <= uend_q ? ST_END : ST_BODY;
                end
                ST_END: begin
                    st_q       <= ST_HDR;
                    held_v_q   <= 1'b0;
                    esc_q      <= 1'b0;
                    prune_q    <= 1'b0;
                    drop_q     <= 1'b0;
                    long_q     <= 1'b0;
                    discard_q  <= 1'b0;
                    byte_cnt_q <= '0;
                end
                default: st_q <= ST_HDR;
            endcase
        end
    end

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_last  = beat.last;
    assign out_drop  = beat.drop;
    assign out_port  = port_q;

    assert_port_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> $stable(out_port));

    assert_discard_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        discard_q |=> !out_valid);

    assert_len_cap_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HDR) || (byte_cnt_q <= cfg_max_len));

endmodule

// File: tb/tb_xtr_stream_decoder.sv
module tb_xtr_stream_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_swap = 1'b0;
    logic [64:0] cfg_port_en = '1;
    logic [15:0] cfg_max_len = 16'd2000;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, out_valid, out_last, out_drop;
    logic [7:0]  out_data;
    logic [6:0]  out_port;

    int    ntests = 0;
    int    nfails = 0;
    int    fseed  = 0;
    string cur_tag = "R13";
    int    cur_port = 0;
    logic [7:0] exp_data[$];
    bit         exp_last[$];
    bit         exp_drop[$];

    always #10 clk = ~clk;

    xtr_stream_decoder dut (
        .clk(clk), .rst(rst), .cfg_swap(cfg_swap), .cfg_port_en(cfg_port_en),
        .cfg_max_len(cfg_max_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_drop(out_drop), .out_port(out_port)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        ntests++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison of every output beat against the reference queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_data.size() == 0) begin
                check(1'b0, cur_tag, "unexpected beat", out_data, 0);
            end else begin
                logic [7:0] d;
                bit l, dr;
                d  = exp_data.pop_front();
                l  = exp_last.pop_front();
                dr = exp_drop.pop_front();
                check(out_data == d && out_last == l && out_drop == dr &&
                      int'(out_port) == cur_port, cur_tag, "beat {data,last,drop,port}",
                      {out_data, 3'b0, out_last, 3'b0, out_drop, 1'b0, out_port},
                      {d, 3'b0, l, 3'b0, dr, 1'b0, 7'(cur_port)});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfails++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = cfg_swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // term: 0 end code with v valid bytes, 1 abort, 2 prune
    task automatic run_frame(input int port, input int ndata, input int v, input int term,
                             input int esc_at, input int nr_at, input string tag);
        logic [31:0] words[$];
        logic [7:0]  pushed[$];
        bit ok, long_f, drop;
        int n;
        cur_tag  = tag;
        cur_port = port;
        for (int i = 0; i < ndata; i++) begin
            if (i == esc_at) words.push_back(32'h8000_0005);
            else words.push_back({8'(16 + i), 8'(32 + i), 8'(48 + i), 8'(fseed)});
        end
        fseed++;
        for (int i = 0; i < ndata; i++) begin
            int nb;
            nb = 4;
            if (term == 0 && i == ndata - 1) nb = v;
            if (term == 1 && i == ndata - 1) nb = 0;
            for (int b = 0; b < nb; b++) pushed.push_back(words[i][31 - 8*b -: 8]);
        end
        ok = (port < 65) && cfg_port_en[port];
        long_f = pushed.size() > int'(cfg_max_len);
        while (pushed.size() > int'(cfg_max_len)) void'(pushed.pop_back());
        drop = (term != 0) || long_f;
        n = pushed.size();
        if (ok && n >= 5) begin
            for (int k = 0; k < n - 4; k++) begin
                exp_data.push_back(pushed[k]);
                exp_last.push_back(k == n - 5);
                exp_drop.push_back((k == n - 5) && drop);
            end
        end
        for (int k = 0; k < 9; k++) begin
            if (k == 7) send_word((32'(port) << 14) | 32'h0000_1003);
            else send_word(32'h0102_0300 + 32'(k));
        end
        for (int i = 0; i < ndata; i++) begin
            if (i == nr_at)  send_word(32'h8000_0007);
            if (i == esc_at) send_word(32'h8000_0006);
            send_word(words[i]);
        end
        if (term == 0) send_word(32'h8000_0000 | 32'(4 - v));
        else if (term == 1) send_word(32'h8000_0005);
        else begin
            send_word(32'h8000_0004);
            send_word(32'h1234_5678);
        end
        repeat (12) @(negedge clk);
        check(exp_data.size() == 0, tag, "beats still expected at frame end",
              exp_data.size(), 0);
        exp_data.delete();
        exp_last.delete();
        exp_drop.delete();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R13", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);

        run_frame(5, 6, 4, 0, -1, -1, "R1_R4");   // 24 bytes, 20 delivered
        run_frame(9, 5, 3, 0, -1, -1, "R3");      // 19 bytes
        run_frame(12, 3, 1, 0, -1, -1, "R3");     // 9 bytes, 5 delivered
        run_frame(2, 1, 4, 0, -1, -1, "R4");      // 4 bytes, nothing
        run_frame(3, 2, 2, 0, -1, -1, "R4");      // 6 bytes, 2 delivered
        run_frame(64, 5, 4, 0, 2, -1, "R5");      // escaped 0x80000005 literal
        run_frame(40, 5, 4, 0, -1, 0, "R6");      // not-ready before first word
        run_frame(41, 5, 2, 0, -1, 3, "R6");      // not-ready mid frame
        run_frame(6, 4, 4, 1, -1, -1, "R7");      // abort: 12 counted, 8 delivered
        run_frame(7, 3, 4, 2, -1, -1, "R8");      // prune: 12 counted, 8 delivered
        run_frame(8, 1, 4, 2, -1, -1, "R8");      // prune of short frame, nothing

        cfg_swap = 1'b1;
        run_frame(33, 5, 3, 0, 1, 2, "R9");
        cfg_swap = 1'b0;

        cfg_port_en[20] = 1'b0;
        run_frame(20, 6, 4, 0, -1, -1, "R10");    // disabled port
        run_frame(100, 6, 4, 0, 2, -1, "R10");    // out of range port
        run_frame(21, 6, 4, 0, -1, -1, "R2");     // recovery after discard
        cfg_port_en[20] = 1'b1;

        cfg_max_len = 16'd16;
        run_frame(11, 8, 4, 0, -1, -1, "R11");    // 32 bytes cut to 16, drop
        run_frame(13, 4, 4, 0, -1, -1, "R12");    // exactly at limit, no drop
        cfg_max_len = 16'd2000;
        run_frame(127 & 63, 7, 1, 0, -1, -1, "R2");

        $display("[TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end

endmodule